// File: doc/BRIEF.md
# Flash Command Decoder

This block sits between an SRAM-style parallel write bus and the write engine of a flash array. Every write cycle on the bus carries one command byte and an address. The block turns these bytes into a read-source select (array contents, identifier space or status word) and into one-cycle start requests, each with an operation kind, an address and a data byte, for the engine that performs erase, byte program and lock-bit updates.

Erase, program and lock updates each take two bus writes: a setup byte and then a confirm or data byte. The block tracks that pairing and rejects a wrong second byte. It also follows whether the engine is busy or suspended, and it refuses commands that are not legal in the current phase. The engine's busy flag is an input. The erase and program algorithms themselves live outside this block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it rises, `rd_mode_o` is 0 (array), `seq_err_o` is 0, every request pulse is low, no setup is pending and nothing is suspended.
- R2: A bus write is taken when the first of `we_ni`/`ce_ni` rises after both were low. The address and byte used are those present in the last clock cycle with both strobes low. The decoder acts at the first clock edge after that rise. Each low period gives exactly one action, even when the second strobe rises later.
- R3: When idle, byte FFh sets `rd_mode_o`=0 (array), 90h sets 1 (identifier) and 70h sets 2 (status).
- R4: When idle, 50h pulses `clr_status_o` for one cycle and clears `seq_err_o`, and leaves `rd_mode_o` unchanged.
- R5: 20h followed by D0h pulses `op_start_o` with `op_kind_o`=1 (erase). `op_addr_o`/`op_data_o` carry the confirm write, and `rd_mode_o` becomes 2.
- R6: 40h or 10h followed by any byte starts `op_kind_o`=2 (program) with the second write's address and byte, and sets `rd_mode_o`=2.
- R7: 60h followed by 01h, F1h or D0h starts `op_kind_o` 3 (set block lock), 4 (set master lock) or 5 (clear all block locks), and sets `rd_mode_o`=2.
- R8: A second byte that is not a valid confirm for its setup starts nothing, sets `seq_err_o`, sets `rd_mode_o`=2 and returns the decoder to idle.
- R9: While `busy_i` is high, only 70h (status mode) and B0h act. FFh, 90h, 50h and setup bytes leave all outputs unchanged.
- R10: B0h while busy with an erase or program pulses `suspend_req_o` and sets `rd_mode_o`=2. B0h while busy with a lock update, or while a program launched from erase suspend runs, does nothing.
- R11: D0h while suspended and not busy pulses `resume_req_o`, ends the suspension and sets `rd_mode_o`=2.
- R12: While suspended, FFh, 90h and 70h still pick the read source, but 50h gives no `clr_status_o` pulse and leaves `seq_err_o` unchanged.
- R13: In erase suspend, 40h/10h plus data targeting a different block (address bits above `BLK_LSB`) starts a program. The suspended block is refused, as in R8. In program suspend, program setup is ignored.
- R14: Pulling `rst_ni` low aborts a pending setup and any suspension. A following D0h then acts as an idle byte and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_ni | input | 1 | Write strobe, active low |
| ce_ni | input | 1 | Chip select strobe, active low |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus data / command byte |
| busy_i | input | 1 | Write engine busy |
| rd_mode_o | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| op_start_o | output | 1 | One-cycle operation start |
| op_kind_o | output | 3 | Operation kind, valid with start |
| op_addr_o | output | AW | Operation address |
| op_data_o | output | DW | Second-cycle byte |
| suspend_req_o | output | 1 | One-cycle suspend request |
| resume_req_o | output | 1 | One-cycle resume request |
| clr_status_o | output | 1 | One-cycle status clear |
| seq_err_o | output | 1 | Sticky command-sequence error |

## Verification
A bench-side countdown stands in for the engine. Random bytes, drawn mostly from the legal command codes with some arbitrary ones mixed in, are written while that countdown is sometimes running, sometimes suspended and sometimes idle. This separates the idle, running and suspended command filters, because the same byte must produce different results in each phase. Directed sequences cover each confirm code against a wrong one, the same block against a different block during erase suspend, and a write in which the write strobe rises before chip select. That last case shows whether one low period is decoded once or twice. A reset placed between setup and confirm shows whether the pending setup survives.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_STATUS = 2'd2} rd_mode_e;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_ERASE = 3'd1, OP_PROG = 3'd2,
    OP_LOCK_BLK = 3'd3, OP_LOCK_MST = 3'd4, OP_UNLOCK_ALL = 3'd5
  } op_kind_e;
  typedef enum logic [1:0] {ST_READY, ST_ERASE_CFM, ST_PROG_DATA, ST_LOCK_CFM} seq_state_e;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_PROG_A    = 8'h40;
  localparam logic [7:0] CMD_PROG_B    = 8'h10;
  localparam logic [7:0] CMD_LOCK      = 8'h60;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
  localparam logic [7:0] CFM_LOCK_BLK  = 8'h01;
  localparam logic [7:0] CFM_LOCK_MST  = 8'hF1;
endpackage

// File: rtl/cmd_capture.sv
module cmd_capture #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ni,
  input  logic          ce_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          act, act_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act = ~we_ni & ~ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  // first strobe to rise ends the cycle
  assign wr_o   = act_q & ~act;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW      = 20,
  parameter int DW      = 8,
  parameter int BLK_LSB = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          busy_i,
  output rd_mode_e      rd_mode_o,
  output logic          op_start_o,
  output op_kind_e      op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  output logic          suspend_o,
  output logic          resume_o,
  output logic          clr_status_o,
  output logic          seq_err_o
);
  localparam int BW = AW - BLK_LSB;

  seq_state_e    state_q, state_d;
  rd_mode_e      mode_q, mode_d;
  op_kind_e      run_q, run_d, okind_q, okind_d;
  logic [BW-1:0] sblk_q, sblk_d;
  logic          err_q, err_d, esusp_q, esusp_d, psusp_q, psusp_d;
  logic          start_q, start_d, susp_q, susp_d, res_q, res_d, clr_q, clr_d;
  logic [AW-1:0] oaddr_q, oaddr_d;
  logic [DW-1:0] odata_q, odata_d;
  logic [7:0]    cmd;
  logic [BW-1:0] blk;

  assign cmd = data_i[7:0];
  assign blk = addr_i[AW-1:BLK_LSB];

  always_comb begin
    state_d = state_q;  mode_d  = mode_q;   run_d   = run_q;   sblk_d = sblk_q;
    err_d   = err_q;    esusp_d = esusp_q;  psusp_d = psusp_q;
    okind_d = okind_q;  oaddr_d = oaddr_q;  odata_d = odata_q;
    start_d = 1'b0;     susp_d  = 1'b0;     res_d   = 1'b0;    clr_d  = 1'b0;
    if (wr_i) begin
      unique case (state_q)
        ST_ERASE_CFM: begin
          state_d = ST_READY;
          mode_d  = RD_STATUS;
          if (cmd == CMD_CONFIRM) begin
            start_d = 1'b1; okind_d = OP_ERASE; oaddr_d = addr_i; odata_d = data_i;
            run_d   = OP_ERASE; sblk_d = blk;
          end else err_d = 1'b1;
        end
        ST_PROG_DATA: begin
          state_d = ST_READY;
          mode_d  = RD_STATUS;
          if (esusp_q && blk == sblk_q) err_d = 1'b1;
          else begin
            start_d = 1'b1; okind_d = OP_PROG; oaddr_d = addr_i; odata_d = data_i;
            if (!esusp_q) run_d = OP_PROG;
          end
        end
        ST_LOCK_CFM: begin
          state_d = ST_READY;
          mode_d  = RD_STATUS;
          oaddr_d = addr_i;
          odata_d = data_i;
          case (cmd)
            CFM_LOCK_BLK: begin start_d = 1'b1; okind_d = OP_LOCK_BLK;   run_d = OP_LOCK_BLK;   end
            CFM_LOCK_MST: begin start_d = 1'b1; okind_d = OP_LOCK_MST;   run_d = OP_LOCK_MST;   end
            CMD_CONFIRM:  begin start_d = 1'b1; okind_d = OP_UNLOCK_ALL; run_d = OP_UNLOCK_ALL; end
            default:      err_d = 1'b1;
          endcase
        end
        default: begin
          if (busy_i) begin
            // running: only status select and suspend
            if (cmd == CMD_RD_STATUS) mode_d = RD_STATUS;
            else if (cmd == CMD_SUSPEND && !esusp_q && !psusp_q &&
                     (run_q == OP_ERASE || run_q == OP_PROG)) begin
              susp_d = 1'b1;
              mode_d = RD_STATUS;
              if (run_q == OP_ERASE) esusp_d = 1'b1;
              else                   psusp_d = 1'b1;
            end
          end else if (esusp_q || psusp_q) begin
            case (cmd)
              CMD_RD_ARRAY:  mode_d = RD_ARRAY;
              CMD_RD_IDENT:  mode_d = RD_IDENT;
              CMD_RD_STATUS: mode_d = RD_STATUS;
              CMD_CONFIRM: begin
                res_d = 1'b1; esusp_d = 1'b0; psusp_d = 1'b0; mode_d = RD_STATUS;
              end
              CMD_PROG_A, CMD_PROG_B: if (esusp_q) state_d = ST_PROG_DATA;
              default: ;
            endcase
          end else begin
            case (cmd)
              CMD_RD_ARRAY:  mode_d = RD_ARRAY;
              CMD_RD_IDENT:  mode_d = RD_IDENT;
              CMD_RD_STATUS: mode_d = RD_STATUS;
              CMD_CLR_STAT:  begin clr_d = 1'b1; err_d = 1'b0; end
              CMD_ERASE:     state_d = ST_ERASE_CFM;
              CMD_PROG_A, CMD_PROG_B: state_d = ST_PROG_DATA;
              CMD_LOCK:      state_d = ST_LOCK_CFM;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READY;  mode_q  <= RD_ARRAY; run_q   <= OP_NONE; sblk_q <= '0;
      err_q   <= 1'b0;      esusp_q <= 1'b0;     psusp_q <= 1'b0;
      okind_q <= OP_NONE;   oaddr_q <= '0;       odata_q <= '0;
      start_q <= 1'b0;      susp_q  <= 1'b0;     res_q   <= 1'b0;    clr_q  <= 1'b0;
    end else begin
      state_q <= state_d;   mode_q  <= mode_d;   run_q   <= run_d;   sblk_q <= sblk_d;
      err_q   <= err_d;     esusp_q <= esusp_d;  psusp_q <= psusp_d;
      okind_q <= okind_d;   oaddr_q <= oaddr_d;  odata_q <= odata_d;
      start_q <= start_d;   susp_q  <= susp_d;   res_q   <= res_d;   clr_q  <= clr_d;
    end
  end

  assign rd_mode_o    = mode_q;
  assign op_start_o   = start_q;
  assign op_kind_o    = okind_q;
  assign op_addr_o    = oaddr_q;
  assign op_data_o    = odata_q;
  assign suspend_o    = susp_q;
  assign resume_o     = res_q;
  assign clr_status_o = clr_q;
  assign seq_err_o    = err_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW      = 20,
  parameter int DW      = 8,
  parameter int BLK_LSB = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ni,
  input  logic          ce_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          busy_i,
  output logic [1:0]    rd_mode_o,
  output logic          op_start_o,
  output logic [2:0]    op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o,
  output logic          suspend_req_o,
  output logic          resume_req_o,
  output logic          clr_status_o,
  output logic          seq_err_o
);
  logic          wr;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  rd_mode_e      mode;
  op_kind_e      kind;

  cmd_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk_i, .rst_ni, .we_ni, .ce_ni, .addr_i, .data_i,
    .wr_o(wr), .addr_o(wr_addr), .data_o(wr_data)
  );

  cmd_decoder #(.AW(AW), .DW(DW), .BLK_LSB(BLK_LSB)) u_dec (
    .clk_i, .rst_ni,
    .wr_i(wr), .addr_i(wr_addr), .data_i(wr_data), .busy_i,
    .rd_mode_o(mode), .op_start_o, .op_kind_o(kind), .op_addr_o, .op_data_o,
    .suspend_o(suspend_req_o), .resume_o(resume_req_o), .clr_status_o, .seq_err_o
  );

  assign rd_mode_o = mode;
  assign op_kind_o = kind;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic [1:0] rd_mode_o,
  input logic       op_start_o,
  input logic       suspend_req_o,
  input logic       resume_req_o,
  input logic       clr_status_o,
  input logic       seq_err_o
);
  // R2: one action per bus write
  a_r2_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({op_start_o, suspend_req_o, resume_req_o, clr_status_o}));

  a_r5_start_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> rd_mode_o == 2'd2);

  a_r9_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> !$past(busy_i));

  a_r10_susp_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_req_o |-> $past(busy_i) && rd_mode_o == 2'd2);

  a_r11_resume_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_req_o |-> !$past(busy_i) && rd_mode_o == 2'd2);

  a_r4_clr_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_status_o |-> !seq_err_o);

  a_r8_err_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_err_o) |-> rd_mode_o == 2'd2 && !op_start_o);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .rd_mode_o(rd_mode_o),
  .op_start_o(op_start_o), .suspend_req_o(suspend_req_o), .resume_req_o(resume_req_o),
  .clr_status_o(clr_status_o), .seq_err_o(seq_err_o)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int BUSY_LEN = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_n = 1'b1, ce_n = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy;
  logic [1:0]  rd_mode;
  logic        op_start, susp_req, res_req, clr_stat, seq_err;
  logic [2:0]  op_kind;
  logic [19:0] op_addr;
  logic [7:0]  op_data;

  int vec = 0, bad = 0, cyc = 0;
  int unsigned cnt = 0, saved = 0;

  // model state
  int       m_state = 0;
  logic [1:0] m_mode = 0;
  logic     m_err = 0, m_es = 0, m_ps = 0;
  int       m_run = 0;
  logic [3:0] m_blk = 0;
  logic     e_start = 0, e_susp = 0, e_res = 0, e_clr = 0;
  logic [2:0] e_kind = 0;
  logic [19:0] e_addr = 0;
  logic [7:0]  e_data = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .we_ni(we_n), .ce_ni(ce_n), .addr_i(addr), .data_i(data),
    .busy_i(busy), .rd_mode_o(rd_mode), .op_start_o(op_start), .op_kind_o(op_kind),
    .op_addr_o(op_addr), .op_data_o(op_data), .suspend_req_o(susp_req),
    .resume_req_o(res_req), .clr_status_o(clr_stat), .seq_err_o(seq_err)
  );

  // engine stub
  assign busy = (cnt != 0);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cnt <= 0; saved <= 0; end
    else if (op_start) cnt <= BUSY_LEN;
    else if (res_req) cnt <= saved;
    else if (susp_req) begin saved <= cnt; cnt <= 0; end
    else if (cnt != 0) cnt <= cnt - 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic model_reset();
    m_state = 0; m_mode = 0; m_err = 0; m_es = 0; m_ps = 0; m_run = 0; m_blk = 0;
    e_start = 0; e_susp = 0; e_res = 0; e_clr = 0;
  endtask

  task automatic launch(input int k, input logic [19:0] a, input logic [7:0] d);
    e_start = 1; e_kind = 3'(k); e_addr = a; e_data = d;
  endtask

  // expected effect of one bus write, from the requirements
  task automatic model_step(input logic [7:0] d, input logic [19:0] a, input logic b);
    e_start = 0; e_susp = 0; e_res = 0; e_clr = 0;
    case (m_state)
      1: begin m_state = 0; m_mode = 2;
        if (d == 8'hD0) begin launch(1, a, d); m_run = 1; m_blk = a[19:16]; end else m_err = 1; end
      2: begin m_state = 0; m_mode = 2;
        if (m_es && a[19:16] == m_blk) m_err = 1;
        else begin launch(2, a, d); if (!m_es) m_run = 2; end end
      3: begin m_state = 0; m_mode = 2;
        if (d == 8'h01) begin launch(3, a, d); m_run = 3; end
        else if (d == 8'hF1) begin launch(4, a, d); m_run = 4; end
        else if (d == 8'hD0) begin launch(5, a, d); m_run = 5; end
        else m_err = 1; end
      default: begin
        if (b) begin
          if (d == 8'h70) m_mode = 2;
          else if (d == 8'hB0 && !m_es && !m_ps && (m_run == 1 || m_run == 2)) begin
            e_susp = 1; m_mode = 2; if (m_run == 1) m_es = 1; else m_ps = 1;
          end
        end else if (m_es || m_ps) begin
          if (d == 8'hFF) m_mode = 0;
          else if (d == 8'h90) m_mode = 1;
          else if (d == 8'h70) m_mode = 2;
          else if (d == 8'hD0) begin e_res = 1; m_es = 0; m_ps = 0; m_mode = 2; end
          else if ((d == 8'h40 || d == 8'h10) && m_es) m_state = 2;
        end else begin
          if (d == 8'hFF) m_mode = 0;
          else if (d == 8'h90) m_mode = 1;
          else if (d == 8'h70) m_mode = 2;
          else if (d == 8'h50) begin e_clr = 1; m_err = 0; end
          else if (d == 8'h20) m_state = 1;
          else if (d == 8'h40 || d == 8'h10) m_state = 2;
          else if (d == 8'h60) m_state = 3;
        end
      end
    endcase
  endtask

  task automatic check(input string tag);
    bit ok = 1;
    vec++;
    if (rd_mode !== m_mode) begin ok = 0;
      $display("FAIL %s rd_mode act=%0d exp=%0d", tag, rd_mode, m_mode); end
    if (seq_err !== m_err) begin ok = 0;
      $display("FAIL %s seq_err act=%0b exp=%0b", tag, seq_err, m_err); end
    if (op_start !== e_start) begin ok = 0;
      $display("FAIL %s op_start act=%0b exp=%0b", tag, op_start, e_start); end
    else if (e_start && (op_kind !== e_kind || op_addr !== e_addr || op_data !== e_data)) begin ok = 0;
      $display("FAIL %s op act=%0d/%h/%h exp=%0d/%h/%h", tag, op_kind, op_addr, op_data,
               e_kind, e_addr, e_data); end
    if (susp_req !== e_susp) begin ok = 0;
      $display("FAIL %s suspend act=%0b exp=%0b", tag, susp_req, e_susp); end
    if (res_req !== e_res) begin ok = 0;
      $display("FAIL %s resume act=%0b exp=%0b", tag, res_req, e_res); end
    if (clr_stat !== e_clr) begin ok = 0;
      $display("FAIL %s clr_status act=%0b exp=%0b", tag, clr_stat, e_clr); end
    if (!ok) bad++;
  endtask

  task automatic wr(input logic [7:0] d, input logic [19:0] a, input bit we_first, input string tag);
    @(negedge clk); we_n = 0; ce_n = 0; data = d; addr = a;
    @(negedge clk);
    model_step(d, a, busy);
    if (we_first) begin
      we_n = 1;
      @(negedge clk); check(tag);
      ce_n = 1; data = ~d;
      e_start = 0; e_susp = 0; e_res = 0; e_clr = 0;
      @(negedge clk); check(tag);
    end else begin
      we_n = 1; ce_n = 1;
      @(negedge clk); check(tag);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); check("R1");
    rst_n = 1;
    @(negedge clk); check("R1");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk); check("R1");

    wr(8'h90, 20'h00001, 0, "R3");
    wr(8'h70, 20'h00000, 0, "R3");
    wr(8'hFF, 20'h00000, 0, "R3");
    // R5 erase confirm
    wr(8'h20, 20'h35000, 0, "R5");
    wr(8'hD0, 20'h35123, 0, "R5");
    wait_idle();
    // R8 wrong confirm, R4 clears
    wr(8'h20, 20'h20000, 0, "R8");
    wr(8'h55, 20'h20000, 0, "R8");
    wr(8'h50, 20'h00000, 0, "R4");
    // R6 both program setups
    wr(8'h10, 20'h01234, 0, "R6");
    wr(8'hA5, 20'h01234, 0, "R6");
    wait_idle();
    wr(8'h40, 20'h77777, 0, "R6");
    wr(8'h3C, 20'h77778, 0, "R6");
    // R9 read-array ignored while busy
    wr(8'hFF, 20'h0, 0, "R9");
    wr(8'h90, 20'h0, 0, "R9");
    wait_idle();
    // R7 lock confirms
    wr(8'h60, 20'h40000, 0, "R7"); wr(8'h01, 20'h40000, 0, "R7"); wait_idle();
    wr(8'h60, 20'h00000, 0, "R7"); wr(8'hF1, 20'h00000, 0, "R7");
    wr(8'hB0, 20'h0, 0, "R10"); wait_idle();
    wr(8'h60, 20'h00000, 0, "R7"); wr(8'hD0, 20'h00000, 0, "R7"); wait_idle();
    wr(8'h60, 20'h00000, 0, "R8"); wr(8'h77, 20'h00000, 0, "R8");
    // R10 erase suspend, R12, R13, R11
    wr(8'h20, 20'h50000, 0, "R10"); wr(8'hD0, 20'h50000, 0, "R10");
    wr(8'hB0, 20'h0, 0, "R10");
    repeat (2) @(negedge clk);
    wr(8'h50, 20'h0, 0, "R12");
    wr(8'hFF, 20'h0, 0, "R12");
    wr(8'h40, 20'h5ABCD, 0, "R13"); wr(8'h11, 20'h5ABCD, 0, "R13");
    wr(8'h10, 20'h6ABCD, 0, "R13"); wr(8'h22, 20'h6ABCD, 0, "R13");
    wr(8'hB0, 20'h0, 0, "R10");
    wait_idle();
    wr(8'hD0, 20'h0, 0, "R11");
    wait_idle();
    // program suspend: setup ignored
    wr(8'h40, 20'h10000, 0, "R13"); wr(8'h99, 20'h10000, 0, "R13");
    wr(8'hB0, 20'h0, 0, "R10");
    repeat (2) @(negedge clk);
    wr(8'h40, 20'h30000, 0, "R13");
    wr(8'hD0, 20'h0, 0, "R11");
    wait_idle();
    // R2 write strobe rises before chip select
    wr(8'h90, 20'h00003, 1, "R2");
    wr(8'h20, 20'h80000, 1, "R2"); wr(8'hD0, 20'h80001, 1, "R2");
    wait_idle();
    // R14 reset between setup and confirm
    wr(8'h20, 20'h90000, 0, "R14");
    do_reset();
    wr(8'hD0, 20'h90000, 0, "R14");
    wr(8'h40, 20'h90000, 0, "R14"); wr(8'hB0, 20'hA0000, 0, "R14");
    wr(8'hB0, 20'h0, 0, "R14");
    do_reset();

    for (int i = 0; i < 500; i++) begin
      logic [7:0] d;
      int sel = $urandom_range(0, 14);
      case (sel)
        0: d = 8'hFF; 1: d = 8'h90; 2: d = 8'h70; 3: d = 8'h50; 4: d = 8'h20;
        5, 6: d = 8'hD0; 7: d = 8'h40; 8: d = 8'h10; 9: d = 8'h60; 10: d = 8'h01;
        11: d = 8'hF1; 12, 13: d = 8'hB0;
        default: d = 8'($urandom);
      endcase
      wr(d, 20'($urandom), bit'($urandom_range(0, 3) == 0), "R9");
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule